// File: doc/BRIEF.md
# Circuit Guard for a Data-Plane Input Port

This block sits at one input port of a circuit-switched data plane. The port keeps a flit buffer and a reservation buffer. At any moment the reservation buffer has realized one circuit, and that circuit's reservation records the destination and request id of the request that built it. When the flit at the front of the buffer is a head flit, the guard checks that it belongs to that circuit. Both its destination and its request id must equal those of the realized reservation. The comparison runs in the same cycle as the flit crosses the switch, so a hop still costs one cycle. The flit's payload leaves speculatively, and the match result is ANDed into the data-valid sent to the next port. On a mismatch that valid is cleared, so the next port drops whatever it sees.

On a mismatch the guard keeps the head flit in the buffer and does not send the message. In the following cycle it sends a one-flit removal message down the wrong circuit, which consumes that circuit's reservations. In the same cycle it tells the reservation buffer to drop its current reservation. The drop is marked "early" when no upstream remove signal came with the mismatch, and the reservation buffer must then ignore the next upstream remove. The guard then returns to head checking. The held flit is compared again against whichever circuit the reservation buffer realizes next, which is the earliest-EUC reservation, and it leaves once it matches.

The controller has three states. **HEAD_CHECK** waits for a head flit and compares it. **BODY_FLOW** forwards the body flits of a message that was accepted. **PURGE** emits the removal message. The transitions are:
- *accept-single*: HEAD_CHECK to HEAD_CHECK, on a matching head that is also a tail.
- *accept-multi*: HEAD_CHECK to BODY_FLOW, on a matching head that is not a tail.
- *misroute*: HEAD_CHECK to PURGE, on a mismatching head.
- *tail-done*: BODY_FLOW to HEAD_CHECK, when the tail is sent.
- *purge-sent*: PURGE to HEAD_CHECK, when the removal message leaves.
- *stall*: any state stays where it is while its transfer cannot happen.

Top module: `circuit_guard`

## Requirements
- R1: While rst_n is low, out_valid, fb_pop and rb_drop stay 0 whatever the inputs are. After reset the guard is in HEAD_CHECK.
- R2: In HEAD_CHECK, when fb_valid, fb_head, rc_valid and dn_ready are all 1 and both fb_dest==rc_dest and fb_reqid==rc_reqid hold, out_valid and fb_pop are 1 in that same cycle. out_data, out_dest and out_reqid then equal the flit's fields, and out_rmc is 0.
- R3: In HEAD_CHECK, when such a head flit differs from the realized circuit in its destination, its request id or both, out_valid and fb_pop are 0 in that cycle.
- R4: In the first cycle after a mismatch in which dn_ready is 1, the guard emits the removal flit. That flit has out_valid=1, out_rmc=1, out_head=1, out_tail=1, out_data=0, and out_dest and out_reqid equal to the rejected circuit's rc_dest and rc_reqid. rb_drop=1 and fb_pop=0 in that cycle.
- R5: rb_skip_remove is 1 exactly in the cycle the removal flit is sent, and only if up_remove was 0 in the mismatch cycle. Otherwise it is 0.
- R6: While PURGE waits on dn_ready=0, out_valid and rb_drop are 0, and the removal flit goes out in the first cycle dn_ready returns to 1.
- R7: After the removal flit, the held head flit is compared again against the realized circuit. If it matches, it is sent in the first cycle the transfer conditions of R2 hold.
- R8: In BODY_FLOW, body flits are forwarded and popped without any comparison whenever fb_valid, rc_valid and dn_ready are 1. The flit marked tail returns the guard to HEAD_CHECK.
- R9: No flit is forwarded or popped in a cycle where dn_ready, rc_valid or fb_valid is 0.
- R10: A matching head flit that also carries the tail marker is sent alone, and the next head flit is compared again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fb_valid | input | 1 | Flit buffer holds a flit at its front |
| fb_head | input | 1 | Front flit is a head flit |
| fb_tail | input | 1 | Front flit is the last flit of its message |
| fb_dest | input | DEST_W | Destination carried by the message |
| fb_reqid | input | ID_W | Request id carried by the message |
| fb_data | input | DATA_W | Flit payload |
| fb_pop | output | 1 | Remove the front flit from the buffer |
| rc_valid | input | 1 | A circuit is currently realized |
| rc_dest | input | DEST_W | Destination recorded in the realized reservation |
| rc_reqid | input | ID_W | Request id recorded in the realized reservation |
| up_remove | input | 1 | Upstream signal to remove the current reservation |
| dn_ready | input | 1 | Switch and downstream port can take a flit this cycle |
| out_valid | output | 1 | Gated data-valid toward the next input port |
| out_head | output | 1 | Outgoing flit is a head flit |
| out_tail | output | 1 | Outgoing flit is a tail flit |
| out_rmc | output | 1 | Outgoing flit is the circuit removal message |
| out_dest | output | DEST_W | Destination field of the outgoing flit |
| out_reqid | output | ID_W | Request id field of the outgoing flit |
| out_data | output | DATA_W | Payload of the outgoing flit |
| rb_drop | output | 1 | Reservation buffer drops its realized reservation |
| rb_skip_remove | output | 1 | Reservation buffer ignores its next upstream remove |

## Verification
The assertions take a well-formed flit stream for granted. In HEAD_CHECK the front flit is always a head flit, and in BODY_FLOW it is always a body or tail flit of the message that was accepted. They also assume the realized circuit does not change in the middle of a message. The stimulus builds every message as one head flit followed by body flits and a tail. It changes rc_dest and rc_reqid only while the guard waits for a head, or right after a removal flit, so every input pattern stays inside those limits.

// File: rtl/cg_pkg.sv
package cg_pkg;

    typedef enum logic [1:0] {
        ST_HEAD  = 2'd0,
        ST_BODY  = 2'd1,
        ST_PURGE = 2'd2
    } cg_state_e;

endpackage

// File: rtl/cg_match.sv
module cg_match #(
    parameter int DEST_W = 6,
    parameter int ID_W   = 4
) (
    input  logic [DEST_W-1:0] msg_dest,
    input  logic [ID_W-1:0]   msg_id,
    input  logic [DEST_W-1:0] cir_dest,
    input  logic [ID_W-1:0]   cir_id,
    output logic              hit
);

    localparam int KEY_W = DEST_W + ID_W;

    logic [KEY_W-1:0] diff;

    // One XOR per key bit: destination bits sit above the id bits.
    for (genvar b = 0; b < KEY_W; b++) begin : g_bit
        if (b < ID_W) begin : g_id
            assign diff[b] = msg_id[b] ^ cir_id[b];
        end else begin : g_dst
            assign diff[b] = msg_dest[b-ID_W] ^ cir_dest[b-ID_W];
        end
    end

    assign hit = ~|diff;

endmodule

// File: rtl/cg_victim.sv
module cg_victim #(
    parameter int DEST_W = 6,
    parameter int ID_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic              up_remove,
    input  logic [DEST_W-1:0] cir_dest,
    input  logic [ID_W-1:0]   cir_id,
    output logic [DEST_W-1:0] v_dest,
    output logic [ID_W-1:0]   v_id,
    output logic              v_early
);

    // Holds the rejected circuit's key, and whether the upstream remove had
    // not yet arrived when the misroute was seen.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_dest  <= '0;
            v_id    <= '0;
            v_early <= 1'b0;
        end else if (capture) begin
            v_dest  <= cir_dest;
            v_id    <= cir_id;
            v_early <= ~up_remove;
        end
    end

endmodule

// File: rtl/cg_ctrl.sv
module cg_ctrl
    import cg_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      fb_valid,
    input  logic      fb_head,
    input  logic      fb_tail,
    input  logic      rc_valid,
    input  logic      dn_ready,
    input  logic      match,
    output logic      send,
    output logic      pop,
    output logic      purge_now,
    output logic      capture,
    output cg_state_e state
);

    cg_state_e nxt;
    logic      attempt;

    assign attempt = rst_n & fb_valid & rc_valid & dn_ready;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_HEAD;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_HEAD: begin
                if (attempt && fb_head) begin
                    if (!match)       nxt = ST_PURGE;
                    else if (fb_tail) nxt = ST_HEAD;
                    else              nxt = ST_BODY;
                end
            end
            ST_BODY: begin
                if (attempt && fb_tail) nxt = ST_HEAD;
            end
            ST_PURGE: begin
                if (dn_ready) nxt = ST_HEAD;
            end
            default: nxt = ST_HEAD;
        endcase
    end

    always_comb begin
        send      = 1'b0;
        pop       = 1'b0;
        purge_now = 1'b0;
        capture   = 1'b0;
        unique case (state)
            ST_HEAD: begin
                if (attempt && fb_head) begin
                    send    = match;
                    pop     = match;
                    capture = ~match;
                end
            end
            ST_BODY: begin
                send = attempt;
                pop  = attempt;
            end
            ST_PURGE: begin
                purge_now = rst_n & dn_ready;
            end
            default: ;
        endcase
    end

    // R3
    mis_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HEAD && attempt && fb_head && !match) |-> (!send && !pop));

    // R4
    purge_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> (state == ST_PURGE));

    // R6
    purge_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PURGE && !dn_ready) |=> (state == ST_PURGE));

    // R8
    body_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BODY && attempt) |-> (send && pop));

    // R10
    single_flit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HEAD && send && fb_tail) |=> (state == ST_HEAD));

endmodule

// File: rtl/circuit_guard.sv
module circuit_guard
    import cg_pkg::*;
#(
    parameter int DEST_W = 6,
    parameter int ID_W   = 4,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fb_valid,
    input  logic              fb_head,
    input  logic              fb_tail,
    input  logic [DEST_W-1:0] fb_dest,
    input  logic [ID_W-1:0]   fb_reqid,
    input  logic [DATA_W-1:0] fb_data,
    output logic              fb_pop,
    input  logic              rc_valid,
    input  logic [DEST_W-1:0] rc_dest,
    input  logic [ID_W-1:0]   rc_reqid,
    input  logic              up_remove,
    input  logic              dn_ready,
    output logic              out_valid,
    output logic              out_head,
    output logic              out_tail,
    output logic              out_rmc,
    output logic [DEST_W-1:0] out_dest,
    output logic [ID_W-1:0]   out_reqid,
    output logic [DATA_W-1:0] out_data,
    output logic              rb_drop,
    output logic              rb_skip_remove
);

    logic              hit;
    logic              send;
    logic              purge_now;
    logic              capture;
    cg_state_e         state;
    logic [DEST_W-1:0] v_dest;
    logic [ID_W-1:0]   v_id;
    logic              v_early;

    cg_match #(.DEST_W(DEST_W), .ID_W(ID_W)) u_match (
        .msg_dest (fb_dest),
        .msg_id   (fb_reqid),
        .cir_dest (rc_dest),
        .cir_id   (rc_reqid),
        .hit      (hit)
    );

    cg_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .fb_valid  (fb_valid),
        .fb_head   (fb_head),
        .fb_tail   (fb_tail),
        .rc_valid  (rc_valid),
        .dn_ready  (dn_ready),
        .match     (hit),
        .send      (send),
        .pop       (fb_pop),
        .purge_now (purge_now),
        .capture   (capture),
        .state     (state)
    );

    cg_victim #(.DEST_W(DEST_W), .ID_W(ID_W)) u_victim (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture   (capture),
        .up_remove (up_remove),
        .cir_dest  (rc_dest),
        .cir_id    (rc_reqid),
        .v_dest    (v_dest),
        .v_id      (v_id),
        .v_early   (v_early)
    );

    // The payload crosses the switch speculatively; only the valid is gated.
    assign out_valid      = send | purge_now;
    assign out_rmc        = purge_now;
    assign out_head       = purge_now ? 1'b1 : fb_head;
    assign out_tail       = purge_now ? 1'b1 : fb_tail;
    assign out_dest       = purge_now ? v_dest : fb_dest;
    assign out_reqid      = purge_now ? v_id : fb_reqid;
    assign out_data       = purge_now ? '0 : fb_data;
    assign rb_drop        = purge_now;
    assign rb_skip_remove = purge_now & v_early;

    // R9
    blocked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!dn_ready || !rc_valid && state != ST_PURGE) |-> (!out_valid && !fb_pop));

    // R5
    skip_needs_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rb_skip_remove |-> (rb_drop && out_rmc && out_valid));

    // R2
    pop_is_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fb_pop |-> (out_valid && !out_rmc && fb_valid));

    // R4
    drop_no_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rb_drop |-> (!fb_pop && out_head && out_tail));

endmodule

// File: tb/test_circuit_guard.sv
module test_circuit_guard;

    localparam int DEST_W = 6;
    localparam int ID_W   = 4;
    localparam int DATA_W = 16;

    typedef struct {
        bit head;
        bit tail;
        int dest;
        int id;
        int data;
    } mflit_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              fb_valid = 1'b0, fb_head = 1'b0, fb_tail = 1'b0;
    logic [DEST_W-1:0] fb_dest = '0;
    logic [ID_W-1:0]   fb_reqid = '0;
    logic [DATA_W-1:0] fb_data = '0;
    logic              fb_pop;
    logic              rc_valid = 1'b0;
    logic [DEST_W-1:0] rc_dest = '0;
    logic [ID_W-1:0]   rc_reqid = '0;
    logic              up_remove = 1'b0, dn_ready = 1'b0;
    logic              out_valid, out_head, out_tail, out_rmc;
    logic [DEST_W-1:0] out_dest;
    logic [ID_W-1:0]   out_reqid;
    logic [DATA_W-1:0] out_data;
    logic              rb_drop, rb_skip_remove;

    circuit_guard #(.DEST_W(DEST_W), .ID_W(ID_W), .DATA_W(DATA_W)) i_circuit_guard (
        .clk(clk), .rst_n(rst_n),
        .fb_valid(fb_valid), .fb_head(fb_head), .fb_tail(fb_tail),
        .fb_dest(fb_dest), .fb_reqid(fb_reqid), .fb_data(fb_data), .fb_pop(fb_pop),
        .rc_valid(rc_valid), .rc_dest(rc_dest), .rc_reqid(rc_reqid),
        .up_remove(up_remove), .dn_ready(dn_ready),
        .out_valid(out_valid), .out_head(out_head), .out_tail(out_tail), .out_rmc(out_rmc),
        .out_dest(out_dest), .out_reqid(out_reqid), .out_data(out_data),
        .rb_drop(rb_drop), .rb_skip_remove(rb_skip_remove)
    );

    always #10 clk = ~clk;

    int     n_checks = 0;
    int     n_fails  = 0;
    bit     done     = 1'b0;
    mflit_t q[$];

    // reference model state: 0 waiting head, 1 in message, 2 removal pending
    int mode = 0;
    int vdest = 0, vid = 0;
    bit vearly = 1'b0;
    bit resumed = 1'b0;

    task automatic chk(string req, string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic add_msg(int dest, int id, int len, int base);
        for (int k = 0; k < len; k++) begin
            mflit_t f;
            f.head = (k == 0);
            f.tail = (k == len - 1);
            f.dest = dest;
            f.id   = id;
            f.data = (base + k) & 16'hFFFF;
            q.push_back(f);
        end
    endtask

    task automatic cycle();
        bit e_valid, e_pop, e_drop, e_skip, e_rmc, e_head, e_tail;
        int e_dest, e_id, e_data, nmode;
        bit cap, nres;
        string req;
        if (q.size() > 0) begin
            fb_valid = 1'b1;
            fb_head  = q[0].head;
            fb_tail  = q[0].tail;
            fb_dest  = q[0].dest[DEST_W-1:0];
            fb_reqid = q[0].id[ID_W-1:0];
            fb_data  = q[0].data[DATA_W-1:0];
        end else begin
            fb_valid = 1'b0;
        end
        #5;
        e_valid = 0; e_pop = 0; e_drop = 0; e_skip = 0; e_rmc = 0;
        e_head = 0; e_tail = 0; e_dest = 0; e_id = 0; e_data = 0;
        nmode = mode; cap = 0; nres = resumed; req = "R9";
        if (!rst_n) begin
            req = "R1";
            nmode = 0;
        end else if (mode == 0) begin
            if (fb_valid && rc_valid && dn_ready && fb_head) begin
                if (int'(fb_dest) == int'(rc_dest) && int'(fb_reqid) == int'(rc_reqid)) begin
                    e_valid = 1; e_pop = 1; e_head = 1; e_tail = fb_tail;
                    e_dest = fb_dest; e_id = fb_reqid; e_data = fb_data;
                    nmode = fb_tail ? 0 : 1;
                    req = resumed ? "R7" : (fb_tail ? "R10" : "R2");
                    nres = 0;
                end else begin
                    req = "R3";
                    nmode = 2;
                    cap = 1;
                end
            end
        end else if (mode == 1) begin
            if (fb_valid && rc_valid && dn_ready) begin
                e_valid = 1; e_pop = 1; e_head = 0; e_tail = fb_tail;
                e_dest = fb_dest; e_id = fb_reqid; e_data = fb_data;
                nmode = fb_tail ? 0 : 1;
                req = "R8";
            end
        end else begin
            if (dn_ready) begin
                e_valid = 1; e_rmc = 1; e_head = 1; e_tail = 1;
                e_dest = vdest; e_id = vid; e_data = 0;
                e_drop = 1; e_skip = vearly;
                nmode = 0; nres = 1;
                req = vearly ? "R5" : "R4";
            end else begin
                req = "R6";
            end
        end
        chk(req, "out_valid", out_valid, e_valid);
        chk(req, "fb_pop", fb_pop, e_pop);
        chk(req, "rb_drop", rb_drop, e_drop);
        chk(req, "rb_skip_remove", rb_skip_remove, e_skip);
        if (e_valid) begin
            chk(req, "out_rmc", out_rmc, e_rmc);
            chk(req, "out_head", out_head, e_head);
            chk(req, "out_tail", out_tail, e_tail);
            chk(req, "out_dest", int'(out_dest), e_dest);
            chk(req, "out_reqid", int'(out_reqid), e_id);
            chk(req, "out_data", int'(out_data), e_data);
        end
        @(posedge clk);
        if (cap) begin
            vdest  = rc_dest;
            vid    = rc_reqid;
            vearly = !up_remove;
        end
        if (e_pop) void'(q.pop_front());
        mode = nmode;
        resumed = nres;
        @(negedge clk);
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        // R1: reset gates everything even with a matching head ready
        rc_valid = 1; rc_dest = 6'd5; rc_reqid = 4'd2; dn_ready = 1;
        add_msg(5, 2, 3, 16'h100);
        for (int i = 0; i < 3; i++) cycle();
        rst_n = 1;
        // R2, R8: matching three-flit message
        for (int i = 0; i < 3; i++) cycle();
        // R10: single-flit messages back to back
        add_msg(5, 2, 1, 16'h200);
        add_msg(5, 2, 1, 16'h210);
        cycle(); cycle();
        // R3, R5 early: destination mismatch, no upstream remove
        add_msg(9, 2, 2, 16'h300);
        cycle();
        cycle();
        rc_dest = 6'd9;
        // R7: resume on the newly realized circuit
        cycle(); cycle();
        // R3, R4, R6: id mismatch with upstream remove seen, purge stalls
        add_msg(9, 7, 2, 16'h400);
        up_remove = 1;
        cycle();
        up_remove = 0;
        dn_ready = 0;
        cycle(); cycle();
        dn_ready = 1;
        cycle();
        rc_reqid = 4'd7;
        cycle(); cycle();
        // R9: circuit not realized, then downstream stalls mid-message
        add_msg(9, 7, 4, 16'h500);
        rc_valid = 0;
        cycle(); cycle();
        rc_valid = 1;
        cycle();
        dn_ready = 0;
        cycle(); cycle();
        dn_ready = 1;
        for (int i = 0; i < 4; i++) cycle();
        // mixed traffic with a stall pattern on dn_ready
        for (int m = 0; m < 20; m++) add_msg(9, 7, 1 + (m % 4), 16'h1000 + 16 * m);
        for (int i = 0; i < 120; i++) begin
            dn_ready = ((i % 3) != 2);
            up_remove = 0;
            cycle();
        end
        // R3 with both fields wrong, then recover
        dn_ready = 1;
        add_msg(3, 1, 2, 16'h700);
        cycle();
        cycle();
        rc_dest = 6'd3; rc_reqid = 4'd1;
        for (int i = 0; i < 4; i++) cycle();
        chk("R8", "buffer drained", q.size(), 0);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule